// File: doc/BRIEF.md
# Host Slave Data Buffer Interface

This block sits between an 8-bit host bus and a local controller. The host sees two byte registers: an inbound register that it fills by writing, and an outbound register that it empties by reading. It also sees a status byte. A host write can be marked as a command or as data by the address line, and the status byte records which kind came last. The status byte also records whether each buffer is occupied, holds one local flag that the controller sets and clears itself, and holds four bits whose meaning is up to the local firmware.

The host strobes are asynchronous to the block clock. Chip select, read, write and the address line pass together through a synchroniser. Every flag change the host causes is taken on the synchronised trailing (rising) edge of its strobe. While the host is reading the status byte, the host-visible copy is frozen. Local changes made meanwhile collect in a working copy and appear as soon as the read ends. The local controller reads the inbound register, loads the outbound register, writes the user nibble and sets or clears its flag, each with a single-cycle pulse.

Top module: `hsb_slave_buf`

## Requirements
- R1: The status byte is, from bit 7 down, four user bits, the command flag (bit 3), the local flag (bit 2), inbound-full (bit 1) and outbound-full (bit 0). After reset it reads 0x00 and `host_dout_en` is low.
- R2: On the synchronised trailing edge of a host write with chip select low, `host_din` is loaded into the inbound register and inbound-full is set. The command flag takes the value of `host_a0`: 1 for a command, 0 for data. Address and data must be held until that edge is synchronised (three clocks after the strobe rises).
- R3: While chip select and read are both low, `host_dout_en` is high. `host_dout` then carries the status byte when `host_a0` is 1 and the outbound register when `host_a0` is 0.
- R4: No flag changes while a host strobe is still low. A host-caused change is visible no later than four clock cycles after the strobe rises.
- R5: While a synchronised host status read is in progress, the status byte seen by the host and on `loc_status` holds still. Local changes made during the read appear once the read ends.
- R6: A local user-status write copies `loc_sts_byte[7:4]` into status bits 7:4 and leaves bits 3:0 unchanged.
- R7: A local outbound write loads the outbound register and sets outbound-full. The trailing edge of a host read of the outbound register clears outbound-full. When both happen in the same cycle, the flag stays set.
- R8: A local inbound read clears inbound-full. If a host write event lands in the same cycle, inbound-full stays set.
- R9: `loc_f0_set` sets the local flag and `loc_f0_clr` clears it. When both are asserted together, the flag is set.
- R10: While chip select is high, host strobes change no flag and no register, and `host_dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address: 1 command/status, 0 data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_dout_en | output | 1 | High while the host read data is driven |
| loc_in_rd | input | 1 | Local pulse: inbound register consumed |
| loc_in_data | output | 8 | Inbound register contents |
| loc_out_wr | input | 1 | Local pulse: load outbound register |
| loc_out_data | input | 8 | Outbound data from the local side |
| loc_sts_wr | input | 1 | Local pulse: write user status nibble |
| loc_sts_byte | input | 8 | Byte whose bits 7:4 feed the user nibble |
| loc_f0_set | input | 1 | Local pulse: set local flag |
| loc_f0_clr | input | 1 | Local pulse: clear local flag |
| loc_status | output | 8 | Status byte as the host sees it |

## Verification
A table of vectors runs through host data writes, host command writes, host reads of both registers and every local operation, in an order where each step flips a different status bit. A wrong bit position, a wrong command flag or a lost occupancy flag then shows up in a distinct vector. Directed cases then hold a strobe low to show that no flag moves early, and pulse the strobes with chip select high to show they are ignored. Other cases make local writes during a host status read, to tell a frozen status byte from one that changes. Finally, local pulses are aligned with the host event cycle, to tell the set-wins priority from the clear-wins one.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int HSB_W      = 8;
  localparam int USR_W      = 4;
  localparam int CTRL_W     = 4;
  localparam int CTRL_CS    = 0;
  localparam int CTRL_RD    = 1;
  localparam int CTRL_WR    = 2;
  localparam int CTRL_A0    = 3;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b0111;

  typedef struct packed {
    logic [USR_W-1:0] usr;
    logic             f1;
    logic             f0;
    logic             ibf;
    logic             obf;
  } hsb_status_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hsb_strobe_edge.sv
module hsb_strobe_edge
  import hsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_s,
  output logic              wr_evt,
  output logic              rd_data_evt,
  output logic              evt_a0,
  output logic              sts_lock
);
  logic [CTRL_W-1:0] ctrl_p_q;
  logic [CTRL_W-1:0] ctrl_p_d;

  assign ctrl_p_d = ctrl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_p_q <= CTRL_IDLE;
    end else begin
      ctrl_p_q <= ctrl_p_d;
    end
  end

  // Trailing edge: strobe was low last cycle, high now; select taken while low.
  assign wr_evt      = ctrl_s[CTRL_WR] & ~ctrl_p_q[CTRL_WR] & ~ctrl_p_q[CTRL_CS];
  assign rd_data_evt = ctrl_s[CTRL_RD] & ~ctrl_p_q[CTRL_RD] & ~ctrl_p_q[CTRL_CS]
                     & ~ctrl_p_q[CTRL_A0];
  assign evt_a0      = ctrl_p_q[CTRL_A0];
  assign sts_lock    = ~ctrl_s[CTRL_CS] & ~ctrl_s[CTRL_RD] & ctrl_s[CTRL_A0];
endmodule

// File: rtl/hsb_status_regs.sv
module hsb_status_regs
  import hsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic             evt_a0,
  input  logic             rd_data_evt,
  input  logic             sts_lock,
  input  logic             loc_in_rd,
  input  logic             loc_out_wr,
  input  logic             loc_sts_wr,
  input  logic [HSB_W-1:0] loc_sts_byte,
  input  logic             loc_f0_set,
  input  logic             loc_f0_clr,
  output hsb_status_t      live_sts,
  output hsb_status_t      vis_sts
);
  hsb_status_t live_q, live_d;
  hsb_status_t vis_q;
  logic        vis_en;
  logic        unused_sts_lo;

  assign unused_sts_lo = ^loc_sts_byte[HSB_W-USR_W-1:0];

  always_comb begin
    live_d = live_q;
    if (loc_sts_wr) live_d.usr = loc_sts_byte[HSB_W-1:HSB_W-USR_W];
    if (loc_f0_clr) live_d.f0  = 1'b0;
    if (loc_f0_set) live_d.f0  = 1'b1;
    if (loc_in_rd)  live_d.ibf = 1'b0;
    if (wr_evt) begin
      live_d.ibf = 1'b1;
      live_d.f1  = evt_a0;
    end
    if (rd_data_evt) live_d.obf = 1'b0;
    if (loc_out_wr)  live_d.obf = 1'b1;
  end

  assign vis_en = ~sts_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= '0;
    end else if (vis_en) begin
      vis_q <= live_d;
    end
  end

  assign live_sts = live_q;
  assign vis_sts  = vis_q;
endmodule

// File: rtl/hsb_slave_buf.sv
module hsb_slave_buf
  import hsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_cs_n,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             host_a0,
  input  logic [HSB_W-1:0] host_din,
  output logic [HSB_W-1:0] host_dout,
  output logic             host_dout_en,
  input  logic             loc_in_rd,
  output logic [HSB_W-1:0] loc_in_data,
  input  logic             loc_out_wr,
  input  logic [HSB_W-1:0] loc_out_data,
  input  logic             loc_sts_wr,
  input  logic [HSB_W-1:0] loc_sts_byte,
  input  logic             loc_f0_set,
  input  logic             loc_f0_clr,
  output logic [HSB_W-1:0] loc_status
);
  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic              wr_evt, rd_data_evt, evt_a0, sts_lock;
  hsb_status_t       live_sts, vis_sts;
  logic [HSB_W-1:0]  in_q, in_d, out_q, out_d;
  logic              in_en, out_en;

  hsb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  always_comb begin
    ctrl_raw          = '0;
    ctrl_raw[CTRL_CS] = host_cs_n;
    ctrl_raw[CTRL_RD] = host_rd_n;
    ctrl_raw[CTRL_WR] = host_wr_n;
    ctrl_raw[CTRL_A0] = host_a0;
  end

  hsb_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(ctrl_raw), .q(ctrl_s)
  );

  hsb_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .ctrl_s(ctrl_s),
    .wr_evt(wr_evt), .rd_data_evt(rd_data_evt), .evt_a0(evt_a0), .sts_lock(sts_lock)
  );

  hsb_status_regs u_sts (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_evt(wr_evt), .evt_a0(evt_a0), .rd_data_evt(rd_data_evt), .sts_lock(sts_lock),
    .loc_in_rd(loc_in_rd), .loc_out_wr(loc_out_wr),
    .loc_sts_wr(loc_sts_wr), .loc_sts_byte(loc_sts_byte),
    .loc_f0_set(loc_f0_set), .loc_f0_clr(loc_f0_clr),
    .live_sts(live_sts), .vis_sts(vis_sts)
  );

  assign in_en  = wr_evt;
  assign in_d   = host_din;
  assign out_en = loc_out_wr;
  assign out_d  = loc_out_data;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      in_q <= '0;
    end else if (in_en) begin
      in_q <= in_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  assign host_dout    = host_a0 ? vis_sts : out_q;
  assign host_dout_en = ~host_cs_n & ~host_rd_n;
  assign loc_in_data  = in_q;
  assign loc_status   = vis_sts;
endmodule

// File: rtl/hsb_slave_buf_chk.sv
module hsb_slave_buf_chk
  import hsb_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_evt,
  input logic             evt_a0,
  input logic             rd_data_evt,
  input logic             sts_lock,
  input logic             loc_out_wr,
  input logic             loc_in_rd,
  input hsb_status_t      live_sts,
  input logic [HSB_W-1:0] loc_status
);
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(sts_lock) |-> $stable(loc_status)); // R5
  AST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_evt |=> live_sts.ibf); // R2
  AST_WR_F1_A0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_evt |=> (live_sts.f1 == $past(evt_a0))); // R2
  AST_OUT_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    loc_out_wr |=> live_sts.obf); // R7
  AST_RD_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data_evt && !loc_out_wr) |=> !live_sts.obf); // R7
  AST_INRD_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (loc_in_rd && !wr_evt) |=> !live_sts.ibf); // R8
endmodule

bind hsb_slave_buf hsb_slave_buf_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_evt(wr_evt), .evt_a0(evt_a0),
  .rd_data_evt(rd_data_evt), .sts_lock(sts_lock), .loc_out_wr(loc_out_wr),
  .loc_in_rd(loc_in_rd), .live_sts(live_sts), .loc_status(loc_status)
);

// File: tb/tb_hsb_slave_buf.sv
module tb_hsb_slave_buf;
  localparam logic [2:0] OP_HW = 3'd0, OP_HR = 3'd1, OP_OW = 3'd2, OP_IR = 3'd3,
                         OP_SW = 3'd4, OP_FS = 3'd5, OP_FC = 3'd6;
  localparam int NV = 13;
  // {op, a0, data, expected status, expected observed byte}
  localparam logic [27:0] VEC [NV] = '{
    {OP_HW, 1'b0, 8'hA5, 8'h02, 8'hA5},
    {OP_IR, 1'b0, 8'h00, 8'h00, 8'hA5},
    {OP_HW, 1'b1, 8'h3C, 8'h0A, 8'h3C},
    {OP_OW, 1'b0, 8'h5A, 8'h0B, 8'h3C},
    {OP_HR, 1'b1, 8'h00, 8'h0B, 8'h0B},
    {OP_HR, 1'b0, 8'h00, 8'h0A, 8'h5A},
    {OP_SW, 1'b0, 8'h9F, 8'h9A, 8'h3C},
    {OP_FS, 1'b0, 8'h00, 8'h9E, 8'h3C},
    {OP_IR, 1'b0, 8'h00, 8'h9C, 8'h3C},
    {OP_HW, 1'b0, 8'h11, 8'h96, 8'h11},
    {OP_FC, 1'b0, 8'h00, 8'h92, 8'h11},
    {OP_SW, 1'b0, 8'h40, 8'h42, 8'h11},
    {OP_HR, 1'b1, 8'h00, 8'h42, 8'h42}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic host_cs_n, host_rd_n, host_wr_n, host_a0;
  logic [7:0] host_din, host_dout, loc_in_data, loc_out_data, loc_sts_byte, loc_status;
  logic host_dout_en, loc_in_rd, loc_out_wr, loc_sts_wr, loc_f0_set, loc_f0_clr;
  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  hsb_slave_buf dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_a0(host_a0), .host_din(host_din),
    .host_dout(host_dout), .host_dout_en(host_dout_en), .loc_in_rd(loc_in_rd),
    .loc_in_data(loc_in_data), .loc_out_wr(loc_out_wr), .loc_out_data(loc_out_data),
    .loc_sts_wr(loc_sts_wr), .loc_sts_byte(loc_sts_byte), .loc_f0_set(loc_f0_set),
    .loc_f0_clr(loc_f0_clr), .loc_status(loc_status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic host_wr(input logic a0, input logic [7:0] d);
    @(negedge clk); host_cs_n = 1'b0; host_a0 = a0; host_din = d; host_wr_n = 1'b0;
    repeat (4) @(negedge clk); host_wr_n = 1'b1;
    repeat (4) @(negedge clk); host_cs_n = 1'b1; host_a0 = 1'b0;
  endtask

  task automatic host_rd(input logic a0, output logic [7:0] d);
    @(negedge clk); host_cs_n = 1'b0; host_a0 = a0; host_rd_n = 1'b0;
    repeat (4) @(negedge clk); d = host_dout; host_rd_n = 1'b1;
    repeat (4) @(negedge clk); host_cs_n = 1'b1; host_a0 = 1'b0;
  endtask

  task automatic loc_op(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    case (op)
      OP_OW: begin loc_out_wr = 1'b1; loc_out_data = d; end
      OP_IR: loc_in_rd = 1'b1;
      OP_SW: begin loc_sts_wr = 1'b1; loc_sts_byte = d; end
      OP_FS: loc_f0_set = 1'b1;
      OP_FC: loc_f0_clr = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    loc_out_wr = 1'b0; loc_in_rd = 1'b0; loc_sts_wr = 1'b0; loc_f0_set = 1'b0; loc_f0_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_a0 = 1'b0;
    host_din = '0; loc_in_rd = 1'b0; loc_out_wr = 1'b0; loc_out_data = '0;
    loc_sts_wr = 1'b0; loc_sts_byte = '0; loc_f0_set = 1'b0; loc_f0_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", loc_status, 8'h00);
    chk("R1 reset dout_en", {7'd0, host_dout_en}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][27:25];
      if (op == OP_HW) begin
        host_wr(VEC[i][24], VEC[i][23:16]);
        rv = loc_in_data;
      end else if (op == OP_HR) begin
        host_rd(VEC[i][24], rv);
      end else begin
        loc_op(op, VEC[i][23:16]);
        rv = loc_in_data;
      end
      chk($sformatf("R1 R2 R3 R6 R7 R8 R9 vec %0d status", i), loc_status, VEC[i][15:8]);
      chk($sformatf("R2 R3 vec %0d data", i), rv, VEC[i][7:0]);
    end

    // R4: command write held low must not move F1 or the inbound register yet
    @(negedge clk); host_cs_n = 1'b0; host_a0 = 1'b1; host_din = 8'h77; host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 status while strobe low", loc_status, 8'h42);
    chk("R4 inbound while strobe low", loc_in_data, 8'h11);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 status after trailing edge", loc_status, 8'h4A);
    chk("R2 inbound after trailing edge", loc_in_data, 8'h77);
    host_cs_n = 1'b1; host_a0 = 1'b0;

    // R10: strobes with chip select high
    @(negedge clk); host_din = 8'hEE; host_wr_n = 1'b0; host_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 dout_en with cs high", {7'd0, host_dout_en}, 8'h00);
    repeat (2) @(negedge clk); host_wr_n = 1'b1; host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 status unchanged", loc_status, 8'h4A);
    chk("R10 inbound unchanged", loc_in_data, 8'h77);

    // R5: local updates during a host status read
    @(negedge clk); host_cs_n = 1'b0; host_a0 = 1'b1; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 dout_en during read", {7'd0, host_dout_en}, 8'h01);
    loc_op(OP_OW, 8'h66);
    loc_op(OP_SW, 8'hF0);
    chk("R5 status frozen", loc_status, 8'h4A);
    chk("R5 host status frozen", host_dout, 8'h4A);
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 pending applied", loc_status, 8'hFB);
    host_cs_n = 1'b1; host_a0 = 1'b0;

    // R7: host data read event and local outbound write in one cycle
    @(negedge clk); host_cs_n = 1'b0; host_a0 = 1'b0; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 outbound read data", host_dout, 8'h66);
    host_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    loc_out_wr = 1'b1; loc_out_data = 8'h99;
    @(negedge clk); loc_out_wr = 1'b0;
    repeat (2) @(negedge clk); host_cs_n = 1'b1;
    chk("R7 set wins over host read", loc_status, 8'hFB);

    // R8: clear inbound, then host write event and local read together
    loc_op(OP_IR, 8'h00);
    chk("R8 inbound read clears", loc_status, 8'hF9);
    @(negedge clk); host_cs_n = 1'b0; host_a0 = 1'b0; host_din = 8'h21; host_wr_n = 1'b0;
    repeat (4) @(negedge clk); host_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    loc_in_rd = 1'b1;
    @(negedge clk); loc_in_rd = 1'b0;
    repeat (2) @(negedge clk); host_cs_n = 1'b1;
    chk("R8 host write wins", loc_status, 8'hF3);
    chk("R2 inbound data", loc_in_data, 8'h21);

    // R9: set and clear together
    @(negedge clk); loc_f0_set = 1'b1; loc_f0_clr = 1'b1;
    @(negedge clk); loc_f0_set = 1'b0; loc_f0_clr = 1'b0;
    @(negedge clk);
    chk("R9 set wins", loc_status, 8'hF7);

    finish_run();
  end
endmodule